// File: doc/BRIEF.md
# Bus-Attached Registered ALU

This block is a 16-bit arithmetic and logic unit placed between two shared buses. It has no direct operand pins. Each operand is captured into its own register from bus A or bus B when a two-bit load code selects it. The unit combines the two stored operands under a 4-bit operation code and a carry input. It produces a 16-bit result and four status flags: zero, negative, carry and signed overflow.

The result leaves the block through a tri-state stage. That stage drives the result bus only while the drive enable is high and releases the bus otherwise, so other agents can use the same wires. A typical bus cycle loads one or both operands on a clock edge. A later cycle then drives the result.

Top module: `bus_alu`

## Requirements
- R1: The operand registers capture on the rising edge of `clk` under `ld_sel`. The codes are: 2'b01 loads only A from `a_bus`, 2'b10 loads only B from `b_bus`, and 2'b11 loads both in the same edge.
- R2: A register that `ld_sel` does not select keeps its contents whatever its bus carries. Code 2'b00 changes neither register.
- R3: A synchronous reset (`rst` high at a rising edge) clears both operand registers to 16'h0000.
- R4: The logic operation codes are: 0 gives A AND B, 1 gives A OR B, 2 gives A XOR B, 3 gives NOT A, 4 passes A and 5 passes B.
- R5: Code 6 gives A + B + `cin`. Carry is the carry out of bit 15. Overflow is set when A and B have equal sign bits and the result's sign bit differs from them.
- R6: Code 7 gives A - B - `cin`. Carry is the borrow out. Overflow is set when A and B have different sign bits and the result's sign bit differs from A's.
- R7: Code 8 gives A + 1. Carry is set when A is 16'hFFFF. Overflow is set when A is 16'h7FFF.
- R8: Code 9 shifts A left by one with `cin` entering bit 0. Carry takes the old bit 15. Overflow is the result's bit 15 XOR the old bit 15.
- R9: Codes 10 to 15 give a result of 16'h0000, with zero set and the other flags clear.
- R10: Zero is set exactly when the result is 16'h0000. Negative equals result bit 15. Carry and overflow are 0 for codes 0 to 5.
- R11: When `drv_en` is low, all 16 bits of `res_bus` are released to high impedance, so another driver's value is seen on the bus. The flags stay valid either way.
- R12: The result and flags are combinational from the stored operands. A value loaded at an edge appears on the bus only after that edge, so loading and driving it take two bus cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_bus | input | 16 | Shared bus A, operand A source |
| b_bus | input | 16 | Shared bus B, operand B source |
| ld_sel | input | 2 | Load code: 00 none, 01 A, 10 B, 11 both |
| op | input | 4 | Operation code |
| cin | input | 1 | Carry / borrow input |
| drv_en | input | 1 | Result bus drive enable |
| res_bus | output | 16 | Tri-stated result |
| fl_zero | output | 1 | Zero flag |
| fl_neg | output | 1 | Negative flag |
| fl_carry | output | 1 | Carry / borrow flag |
| fl_ovf | output | 1 | Signed overflow flag |

## Verification
The bench loads one register at a time while the other bus carries a different value. A wrong load decode would show the stray value when that register is passed to the output. It goes after arithmetic edges: 16'h7FFF+1, 16'hFFFF+1, a subtract that borrows, 16'h8000-1 and a shift that moves a one out. A carry or overflow rule with an inverted term would show as a wrong flag. It also drives the result bus from the bench while the enable is low. A block that failed to release the bus would override that value. A probe just before the loading edge catches a result that skipped the register stage.

// File: rtl/bus_alu.sv
module bus_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_bus,
  input  logic [W-1:0] b_bus,
  input  logic [1:0]   ld_sel,
  input  logic [3:0]   op,
  input  logic         cin,
  input  logic         drv_en,
  output wire  [W-1:0] res_bus,
  output logic         fl_zero,
  output logic         fl_neg,
  output logic         fl_carry,
  output logic         fl_ovf
);
  localparam int MSB = W - 1;

  logic [W-1:0] a_q, b_q, r;
  logic [W:0]   wide;
  logic         co, ov;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (ld_sel[0]) a_q <= a_bus;
      if (ld_sel[1]) b_q <= b_bus;
    end
  end

  always_comb begin
    wide = '0;
    r    = '0;
    co   = 1'b0;
    ov   = 1'b0;
    case (op)
      4'd0: r = a_q & b_q;
      4'd1: r = a_q | b_q;
      4'd2: r = a_q ^ b_q;
      4'd3: r = ~a_q;
      4'd4: r = a_q;
      4'd5: r = b_q;
      4'd6: begin
        wide = {1'b0, a_q} + {1'b0, b_q} + {{W{1'b0}}, cin};
        r    = wide[W-1:0];
        co   = wide[W];
        ov   = (a_q[MSB] == b_q[MSB]) && (r[MSB] != a_q[MSB]);
      end
      4'd7: begin
        wide = {1'b0, a_q} - {1'b0, b_q} - {{W{1'b0}}, cin};
        r    = wide[W-1:0];
        co   = wide[W];
        ov   = (a_q[MSB] != b_q[MSB]) && (r[MSB] != a_q[MSB]);
      end
      4'd8: begin
        wide = {1'b0, a_q} + {{W{1'b0}}, 1'b1};
        r    = wide[W-1:0];
        co   = wide[W];
        ov   = !a_q[MSB] && r[MSB];
      end
      4'd9: begin
        r  = {a_q[W-2:0], cin};
        co = a_q[MSB];
        ov = r[MSB] ^ a_q[MSB];
      end
      default: r = '0;
    endcase
  end

  assign fl_zero  = (r == '0);
  assign fl_neg   = r[MSB];
  assign fl_carry = co;
  assign fl_ovf   = ov;
  assign res_bus  = drv_en ? r : {W{1'bz}};
endmodule

// File: rtl/bus_alu_chk.sv
module bus_alu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_bus,
  input logic [W-1:0] b_bus,
  input logic [1:0]   ld_sel,
  input logic [3:0]   op,
  input logic         drv_en,
  input logic [W-1:0] res_bus,
  input logic         fl_zero,
  input logic         fl_neg,
  input logic         fl_carry,
  input logic         fl_ovf,
  input logic [W-1:0] a_q,
  input logic [W-1:0] b_q
);
  AST_LOAD_A: assert property (@(posedge clk) disable iff (rst)
    ld_sel[0] |=> a_q == $past(a_bus)); // R1
  AST_LOAD_B: assert property (@(posedge clk) disable iff (rst)
    ld_sel[1] |=> b_q == $past(b_bus)); // R1
  AST_HOLD_A: assert property (@(posedge clk) disable iff (rst)
    !ld_sel[0] |=> $stable(a_q)); // R2
  AST_HOLD_B: assert property (@(posedge clk) disable iff (rst)
    !ld_sel[1] |=> $stable(b_q)); // R2
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (a_q == '0) && (b_q == '0)); // R3
  AST_AND_RESULT: assert property (@(posedge clk) disable iff (rst)
    (drv_en && op == 4'd0) |-> res_bus == (a_q & b_q)); // R4
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> fl_zero == (res_bus == '0)); // R10
  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> fl_neg == res_bus[W-1]); // R10
  AST_LOGIC_NO_CV: assert property (@(posedge clk) disable iff (rst)
    (op <= 4'd5) |-> !fl_carry && !fl_ovf); // R10
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op >= 4'd10) |-> fl_zero && !fl_neg && !fl_carry && !fl_ovf); // R9
endmodule

bind bus_alu bus_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .a_bus(a_bus), .b_bus(b_bus), .ld_sel(ld_sel),
  .op(op), .drv_en(drv_en), .res_bus(res_bus), .fl_zero(fl_zero),
  .fl_neg(fl_neg), .fl_carry(fl_carry), .fl_ovf(fl_ovf),
  .a_q(a_q), .b_q(b_q)
);

// File: tb/bus_alu_tb.sv
module bus_alu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a_bus = '0, b_bus = '0;
  logic [1:0]  ld_sel = '0;
  logic [3:0]  op = '0;
  logic        cin = 1'b0, drv_en = 1'b0;
  logic        tb_drv = 1'b0;
  logic [15:0] tb_val = '0;
  wire  [15:0] res_bus;
  logic        fl_zero, fl_neg, fl_carry, fl_ovf;
  int checks = 0, failures = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  assign res_bus = tb_drv ? tb_val : 16'hzzzz;

  bus_alu u_dut (
    .clk(clk), .rst(rst), .a_bus(a_bus), .b_bus(b_bus), .ld_sel(ld_sel),
    .op(op), .cin(cin), .drv_en(drv_en), .res_bus(res_bus),
    .fl_zero(fl_zero), .fl_neg(fl_neg), .fl_carry(fl_carry), .fl_ovf(fl_ovf)
  );

  // {a, b, op, cin, result, flags {z,n,c,v}}
  localparam int NV = 19;
  localparam logic [56:0] VEC [NV] = '{
    {16'hF0F0, 16'h3C3C, 4'd0, 1'b0, 16'h3030, 4'b0000},
    {16'hF0F0, 16'h3C3C, 4'd1, 1'b0, 16'hFCFC, 4'b0100},
    {16'hF0F0, 16'h3C3C, 4'd2, 1'b0, 16'hCCCC, 4'b0100},
    {16'hF0F0, 16'h3C3C, 4'd3, 1'b0, 16'h0F0F, 4'b0000},
    {16'h8000, 16'h1111, 4'd4, 1'b0, 16'h8000, 4'b0100},
    {16'h8000, 16'h0000, 4'd5, 1'b0, 16'h0000, 4'b1000},
    {16'h7FFF, 16'h0001, 4'd6, 1'b0, 16'h8000, 4'b0101},
    {16'hFFFF, 16'h0001, 4'd6, 1'b0, 16'h0000, 4'b1010},
    {16'h1234, 16'h0001, 4'd6, 1'b1, 16'h1236, 4'b0000},
    {16'h0005, 16'h0003, 4'd7, 1'b0, 16'h0002, 4'b0000},
    {16'h0003, 16'h0005, 4'd7, 1'b0, 16'hFFFE, 4'b0110},
    {16'h8000, 16'h0001, 4'd7, 1'b0, 16'h7FFF, 4'b0001},
    {16'h0005, 16'h0004, 4'd7, 1'b1, 16'h0000, 4'b1000},
    {16'hFFFF, 16'h0000, 4'd8, 1'b0, 16'h0000, 4'b1010},
    {16'h7FFF, 16'h0000, 4'd8, 1'b0, 16'h8000, 4'b0101},
    {16'h8001, 16'h0000, 4'd9, 1'b1, 16'h0003, 4'b0011},
    {16'h4000, 16'h0000, 4'd9, 1'b0, 16'h8000, 4'b0101},
    {16'hFFFF, 16'hFFFF, 4'd10, 1'b1, 16'h0000, 4'b1000},
    {16'h1234, 16'h5678, 4'd15, 1'b0, 16'h0000, 4'b1000}
  };

  function automatic string tag_of(input logic [3:0] c);
    if (c <= 4'd5) return "R4";
    if (c == 4'd6) return "R5";
    if (c == 4'd7) return "R6";
    if (c == 4'd8) return "R7";
    if (c == 4'd9) return "R8";
    return "R9";
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] b, input logic [1:0] ld);
    @(negedge clk);
    a_bus = a; b_bus = b; ld_sel = ld;
    @(negedge clk);
    ld_sel = 2'b00;
  endtask

  task automatic show(input logic [3:0] c, input logic ci);
    op = c; cin = ci; drv_en = 1'b1;
    #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R3: reset state
    show(4'd4, 1'b0); chk("R3 A after reset", res_bus, 16'h0000);
    show(4'd5, 1'b0); chk("R3 B after reset", res_bus, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [56:0] v;
      v = VEC[i];
      drv_en = 1'b0;
      load(v[56:41], v[40:25], 2'b11);
      show(v[24:21], v[20]);
      chk(tag_of(v[24:21]), res_bus, v[19:4]);
      chk("R10 flags", {12'h000, fl_zero, fl_neg, fl_carry, fl_ovf}, {12'h000, v[3:0]});
    end

    // R1/R2: single-register loads
    load(16'h1111, 16'h2222, 2'b11);
    load(16'hAAAA, 16'hBBBB, 2'b01);
    show(4'd4, 1'b0); chk("R1 A-only load A", res_bus, 16'hAAAA);
    show(4'd5, 1'b0); chk("R2 A-only load keeps B", res_bus, 16'h2222);
    load(16'hCCCC, 16'hDDDD, 2'b10);
    show(4'd5, 1'b0); chk("R1 B-only load B", res_bus, 16'hDDDD);
    show(4'd4, 1'b0); chk("R2 B-only load keeps A", res_bus, 16'hAAAA);
    load(16'h0101, 16'h0202, 2'b00);
    show(4'd4, 1'b0); chk("R2 no-load keeps A", res_bus, 16'hAAAA);
    show(4'd5, 1'b0); chk("R2 no-load keeps B", res_bus, 16'hDDDD);

    // R12: result follows the load edge, not the bus
    @(negedge clk);
    a_bus = 16'h5555; ld_sel = 2'b01; op = 4'd4; drv_en = 1'b1;
    #2 chk("R12 before edge", res_bus, 16'hAAAA);
    @(negedge clk);
    ld_sel = 2'b00;
    #2 chk("R12 after edge", res_bus, 16'h5555);

    // R11: bus released when drive enable is low, flags still valid
    load(16'h0000, 16'h0000, 2'b01);
    op = 4'd4; drv_en = 1'b0; tb_val = 16'h5A5A; tb_drv = 1'b1;
    #2 chk("R11 released bus", res_bus, 16'h5A5A);
    chk("R11 flags while released", {15'h0, fl_zero}, 16'h0001);
    tb_drv = 1'b0; drv_en = 1'b1;
    #2 chk("R11 driven again", res_bus, 16'h0000);

    // R3: reset after operands were loaded
    load(16'h9999, 16'h7777, 2'b11);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    show(4'd4, 1'b0); chk("R3 A cleared mid-run", res_bus, 16'h0000);
    show(4'd5, 1'b0); chk("R3 B cleared mid-run", res_bus, 16'h0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule